// File: doc/BRIEF.md
# Health-Scored Timing Source Arbiter

This block chooses which of several timing sources drives the timebase, for example two satellite receivers, a local oscillator and an external reference. Every source gets a health score each cycle. The score is a fixed sum of its confidence, its stability and a penalty for its anomaly count. The arbiter prefers the best-scoring eligible source. A source is eligible when it is valid and not quarantined. A healthier challenger takes over only after it has led the active source by a programmable margin on a programmable number of consecutive evaluation ticks. If the active source becomes ineligible, the arbiter moves away from it on the next clock and ignores the dwell rule.

Apart from the source index, the block reports three things:
- a time-quality state (nominal, degraded or holdover), which uses separate entry and exit thresholds;
- a per-output policy word for downstream outputs;
- a diagnostic flag that is raised when two redundant sources disagree about their confidence.

Every change of active source produces a one-cycle log record. The record carries the old and new indices, their scores at the moment of the decision and a reason code.

Top module: `tsa_arbiter`

## Requirements
- R1: While reset is asserted and on leaving it, `act_idx` is 0, `qual` is holdover (2), `log_valid` is 0 and `diag_disagree` is 0.
- R2: The health score of source i is conf + stab + 4*(15 - anom), using the 8-bit confidence, the 8-bit stability and the 4-bit anomaly fields at bit offset i*8 or i*4 of the flat buses. A higher score is healthier.
- R3: A switch for a better source happens at the evaluation tick on which the same eligible challenger has scored strictly more than the active score plus `margin` on `dwell_len` consecutive ticks. Its reason code is 1. A tick on which that condition fails restarts the count.
- R4: A challenger whose score does not exceed the active score plus `margin` never takes over, however many ticks pass.
- R5: If the active source is not eligible and some source is eligible, the clock edge switches to the eligible source with the highest score, with reason code 2. This happens without a tick and without a dwell. With the default parameters, ties go to the lower index.
- R6: Each switchover raises `log_valid` for exactly one cycle. During that cycle `log_to` equals the new `act_idx`, `log_from` equals the previous one, and the two score fields hold the scores used in the decision.
- R7: When no source is eligible, `qual` becomes holdover (2), `act_idx` keeps its last value and nothing is logged.
- R8: With a source active, `qual` moves from nominal (0) to degraded (1) when the active score falls below `thr_poor`. It returns to nominal only when the score reaches `thr_good` or more. Leaving holdover goes to nominal if the score is at least `thr_good`, and to degraded otherwise.
- R9: Output k's policy (2 bits at offset 2k) works as follows:
  - normal (0) in nominal;
  - announce-degraded (1) in degraded;
  - in holdover, mute (3) if `mute_on_hold[k]` is set, else hold-last (2).
- R10: A pulse on `quar_set[i]` quarantines source i from that cycle on. A quarantined source is excluded from selection even when it has the best score. A pulse on `quar_clr` lifts all quarantines from the next cycle.
- R11: One cycle after sources 0 and 1 are both valid and their confidences differ by more than `dis_thr`, `diag_disagree` is 1; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| tick | input | 1 | evaluation tick for margin switching |
| src_valid | input | NSRC | per-source valid flags |
| src_conf | input | NSRC*CW | per-source confidence, flat |
| src_stab | input | NSRC*STW | per-source stability, flat |
| src_anom | input | NSRC*AW | per-source anomaly count, flat |
| quar_set | input | NSRC | quarantine pulse per source |
| quar_clr | input | 1 | clears every quarantine |
| margin | input | SW | advantage a challenger must exceed |
| dwell_len | input | DWL_W | consecutive ticks needed (0 acts as 1) |
| thr_good | input | SW | score needed to reach nominal |
| thr_poor | input | SW | score below which nominal drops to degraded |
| dis_thr | input | CW | confidence gap that flags disagreement |
| mute_on_hold | input | NOUT | per-output choice of mute in holdover |
| act_idx | output | IW | active source index |
| qual | output | 2 | quality state |
| out_pol | output | 2*NOUT | per-output policy |
| diag_disagree | output | 1 | redundant-source disagreement flag |
| log_valid | output | 1 | switchover record strobe |
| log_from | output | IW | previous active source |
| log_to | output | IW | new active source |
| log_from_score | output | SW | score of previous source at decision |
| log_to_score | output | SW | score of new source at decision |
| log_reason | output | 2 | 1 margin switch, 2 forced failover |

## Verification
Some properties are checked on every cycle:
- after any cycle that offered an eligible source, the active source is one of them;
- holdover is reported exactly when nothing was eligible, and in that case the index stays put;
- every change of index coincides with a log record;
- a margin switch only happens on a tick.

Other behaviour only the bench scenarios can show. This includes the score arithmetic, the exact dwell count and its restart, a challenger that stays just inside the margin, the scores in the log, the quality hysteresis band, the policy words, quarantine and its release, and the disagreement flag.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   typedef enum logic [1:0] {
      Q_NOMINAL  = 2'd0,
      Q_DEGRADED = 2'd1,
      Q_HOLDOVER = 2'd2
   } qual_e;

   typedef enum logic [1:0] {
      P_NORMAL   = 2'd0,
      P_ANNOUNCE = 2'd1,
      P_HOLD     = 2'd2,
      P_MUTE     = 2'd3
   } pol_e;

   localparam logic [1:0] RS_MARGIN = 2'd1;
   localparam logic [1:0] RS_FORCED = 2'd2;
endpackage

// File: rtl/tsa_score.sv
module tsa_score #(
   parameter int CW      = 8,
   parameter int STW     = 8,
   parameter int AW      = 4,
   parameter int ANOM_WT = 4,
   parameter int SW      = 10
) (
   input  logic [CW-1:0]  conf,
   input  logic [STW-1:0] stab,
   input  logic [AW-1:0]  anom,
   output logic [SW-1:0]  score
);
   localparam logic [AW-1:0] AMAX = {AW{1'b1}};

   logic [SW-1:0] penalty_room;

   always_comb begin
      penalty_room = SW'(AMAX - anom) * SW'(ANOM_WT);
      score        = SW'(conf) + SW'(stab) + penalty_room;
   end
endmodule

// File: rtl/tsa_pick.sv
module tsa_pick #(
   parameter int NSRC     = 4,
   parameter int SW       = 10,
   parameter int IW       = 2,
   parameter bit TIE_HIGH = 1'b0
) (
   input  logic [NSRC*SW-1:0] scores,
   input  logic [NSRC-1:0]    elig,
   output logic [IW-1:0]      best_idx,
   output logic [SW-1:0]      best_score,
   output logic               any_elig
);
   logic [SW-1:0] s;

   generate
      if (TIE_HIGH) begin : g_tie_high
         always_comb begin
            best_idx   = '0;
            best_score = '0;
            any_elig   = 1'b0;
            for (int i = 0; i < NSRC; i++) begin
               s = scores[i*SW +: SW];
               if (elig[i] && (!any_elig || s >= best_score)) begin
                  best_idx   = IW'(i);
                  best_score = s;
                  any_elig   = 1'b1;
               end
            end
         end
      end else begin : g_tie_low
         always_comb begin
            best_idx   = '0;
            best_score = '0;
            any_elig   = 1'b0;
            for (int i = 0; i < NSRC; i++) begin
               s = scores[i*SW +: SW];
               if (elig[i] && (!any_elig || s > best_score)) begin
                  best_idx   = IW'(i);
                  best_score = s;
                  any_elig   = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tsa_policy.sv
module tsa_policy #(
   parameter int NOUT = 2
) (
   input  logic [1:0]        qual,
   input  logic [NOUT-1:0]   mute_on_hold,
   output logic [2*NOUT-1:0] out_pol
);
   import tsa_pkg::*;

   generate
      for (genvar k = 0; k < NOUT; k++) begin : g_out
         always_comb begin
            case (qual)
               Q_NOMINAL:  out_pol[2*k +: 2] = P_NORMAL;
               Q_DEGRADED: out_pol[2*k +: 2] = P_ANNOUNCE;
               default:    out_pol[2*k +: 2] = mute_on_hold[k] ? P_MUTE : P_HOLD;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/tsa_arbiter.sv
module tsa_arbiter #(
   parameter int NSRC     = 4,
   parameter int NOUT     = 2,
   parameter int CW       = 8,
   parameter int STW      = 8,
   parameter int AW       = 4,
   parameter int ANOM_WT  = 4,
   parameter int DWL_W    = 8,
   parameter int DIS_A    = 0,
   parameter int DIS_B    = 1,
   parameter bit TIE_HIGH = 1'b0,
   localparam int SMAX    = (2**CW - 1) + (2**STW - 1) + ANOM_WT * (2**AW - 1),
   localparam int SW      = $clog2(SMAX + 1),
   localparam int IW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [NSRC-1:0]      src_valid,
   input  logic [NSRC*CW-1:0]   src_conf,
   input  logic [NSRC*STW-1:0]  src_stab,
   input  logic [NSRC*AW-1:0]   src_anom,
   input  logic [NSRC-1:0]      quar_set,
   input  logic                 quar_clr,
   input  logic [SW-1:0]        margin,
   input  logic [DWL_W-1:0]     dwell_len,
   input  logic [SW-1:0]        thr_good,
   input  logic [SW-1:0]        thr_poor,
   input  logic [CW-1:0]        dis_thr,
   input  logic [NOUT-1:0]      mute_on_hold,
   output logic [IW-1:0]        act_idx,
   output logic [1:0]           qual,
   output logic [2*NOUT-1:0]    out_pol,
   output logic                 diag_disagree,
   output logic                 log_valid,
   output logic [IW-1:0]        log_from,
   output logic [IW-1:0]        log_to,
   output logic [SW-1:0]        log_from_score,
   output logic [SW-1:0]        log_to_score,
   output logic [1:0]           log_reason
);
   import tsa_pkg::*;

   // elaboration-time parameter checks
   if (NSRC < 2 || NSRC > 16) begin : g_bad_nsrc
      $error("tsa_arbiter: NSRC must be within 2..16");
   end
   if (NOUT < 1) begin : g_bad_nout
      $error("tsa_arbiter: NOUT must be at least 1");
   end
   if (DIS_A >= NSRC || DIS_B >= NSRC || DIS_A == DIS_B) begin : g_bad_pair
      $error("tsa_arbiter: disagreement pair must name two distinct sources");
   end
   if (DWL_W < 1 || ANOM_WT < 0) begin : g_bad_misc
      $error("tsa_arbiter: bad dwell width or anomaly weight");
   end

   // ---------------- per-source scoring ----------------
   logic [NSRC*SW-1:0] scores;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      tsa_score #(
         .CW(CW), .STW(STW), .AW(AW), .ANOM_WT(ANOM_WT), .SW(SW)
      ) u_score (
         .conf  (src_conf[i*CW +: CW]),
         .stab  (src_stab[i*STW +: STW]),
         .anom  (src_anom[i*AW +: AW]),
         .score (scores[i*SW +: SW])
      );
   end

   // ---------------- eligibility and best pick ----------------
   logic [NSRC-1:0] quar_q;
   logic [NSRC-1:0] elig;
   logic [IW-1:0]   best_idx;
   logic [SW-1:0]   best_score;
   logic            any_elig;

   assign elig = src_valid & ~(quar_q | quar_set);

   tsa_pick #(
      .NSRC(NSRC), .SW(SW), .IW(IW), .TIE_HIGH(TIE_HIGH)
   ) u_pick (
      .scores     (scores),
      .elig       (elig),
      .best_idx   (best_idx),
      .best_score (best_score),
      .any_elig   (any_elig)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        quar_q <= '0;
      else if (quar_clr) quar_q <= quar_set;
      else               quar_q <= quar_q | quar_set;
   end

   // ---------------- switching decision ----------------
   logic [IW-1:0]    act_q;
   logic [IW-1:0]    chal_q;
   logic [DWL_W:0]   cnt_q;
   logic [DWL_W:0]   cnt_nx;
   logic [DWL_W:0]   dwell_eff;
   logic [SW-1:0]    act_score;
   logic [SW:0]      bar;
   logic             act_ok;
   logic             forced;
   logic             chal_ok;
   logic             dwell_hit;
   logic             do_switch;
   logic [SW-1:0]    nxt_score;

   always_comb begin
      act_score = scores[act_q*SW +: SW];
      act_ok    = elig[act_q];
      forced    = !act_ok && any_elig;
      bar       = {1'b0, act_score} + {1'b0, margin};
      chal_ok   = act_ok && (best_idx != act_q) && ({1'b0, best_score} > bar);
      dwell_eff = (dwell_len == '0) ? (DWL_W+1)'(1) : {1'b0, dwell_len};
      cnt_nx    = (chal_q == best_idx && cnt_q != '0) ? cnt_q + 1'b1 : (DWL_W+1)'(1);
      dwell_hit = chal_ok && tick && (cnt_nx >= dwell_eff);
      do_switch = forced || dwell_hit;
      nxt_score = do_switch ? best_score : act_score;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= '0;
         chal_q <= '0;
         cnt_q  <= '0;
      end else if (do_switch) begin
         act_q  <= best_idx;
         cnt_q  <= '0;
      end else if (tick) begin
         if (chal_ok) begin
            chal_q <= best_idx;
            cnt_q  <= cnt_nx;
         end else begin
            cnt_q  <= '0;
         end
      end
   end

   // ---------------- switchover record ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_valid      <= 1'b0;
         log_from       <= '0;
         log_to         <= '0;
         log_from_score <= '0;
         log_to_score   <= '0;
         log_reason     <= '0;
      end else begin
         log_valid <= do_switch;
         if (do_switch) begin
            log_from       <= act_q;
            log_to         <= best_idx;
            log_from_score <= act_score;
            log_to_score   <= best_score;
            log_reason     <= forced ? RS_FORCED : RS_MARGIN;
         end
      end
   end

   // ---------------- quality state with hysteresis ----------------
   qual_e qual_q;
   qual_e qual_nx;

   always_comb begin
      if (!any_elig) begin
         qual_nx = Q_HOLDOVER;
      end else if (qual_q == Q_NOMINAL) begin
         qual_nx = (nxt_score < thr_poor) ? Q_DEGRADED : Q_NOMINAL;
      end else begin
         qual_nx = (nxt_score >= thr_good) ? Q_NOMINAL : Q_DEGRADED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qual_q <= Q_HOLDOVER;
      else        qual_q <= qual_nx;
   end

   // ---------------- redundant-pair disagreement ----------------
   logic [CW-1:0] conf_a;
   logic [CW-1:0] conf_b;
   logic [CW-1:0] conf_gap;

   always_comb begin
      conf_a   = src_conf[DIS_A*CW +: CW];
      conf_b   = src_conf[DIS_B*CW +: CW];
      conf_gap = (conf_a > conf_b) ? conf_a - conf_b : conf_b - conf_a;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) diag_disagree <= 1'b0;
      else        diag_disagree <= src_valid[DIS_A] && src_valid[DIS_B] && (conf_gap > dis_thr);
   end

   // ---------------- outputs ----------------
   tsa_policy #(.NOUT(NOUT)) u_policy (
      .qual         (qual_q),
      .mute_on_hold (mute_on_hold),
      .out_pol      (out_pol)
   );

   assign act_idx = act_q;
   assign qual    = qual_q;

   // ---------------- assertions ----------------
   logic up;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up <= 1'b0;
      else        up <= 1'b1;
   end

   a_r5_active_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (up && $past(any_elig)) |-> ((($past(elig) >> act_idx) & NSRC'(1)) != '0));

   a_r7_holdover_state: assert property (@(posedge clk) disable iff (!rst_n)
      up |-> ((qual == Q_HOLDOVER) == !$past(any_elig)));

   a_r7_index_held: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !$past(any_elig)) |-> ($stable(act_idx) && !log_valid));

   a_r6_change_logged: assert property (@(posedge clk) disable iff (!rst_n)
      up |-> ((act_idx != $past(act_idx)) == log_valid));

   a_r6_log_fields: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> (log_to == act_idx && log_from != log_to));

   a_r3_margin_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (up && log_valid && log_reason == RS_MARGIN) |-> $past(tick));
endmodule

// File: tb/tsa_arbiter_test.sv
`timescale 1ns/1ps
module tsa_arbiter_test;
   localparam int NSRC = 4;
   localparam int NOUT = 2;
   localparam int SW   = 10;
   localparam int IW   = 2;
   localparam int RECW = IW + IW + SW + SW + 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic [NSRC-1:0]   src_valid = '0;
   logic [NSRC*8-1:0] src_conf = '0;
   logic [NSRC*8-1:0] src_stab = '0;
   logic [NSRC*4-1:0] src_anom = '0;
   logic [NSRC-1:0]   quar_set = '0;
   logic              quar_clr = 1'b0;
   logic [SW-1:0]     margin = 10'd20;
   logic [7:0]        dwell_len = 8'd3;
   logic [SW-1:0]     thr_good = 10'd400;
   logic [SW-1:0]     thr_poor = 10'd300;
   logic [7:0]        dis_thr = 8'd50;
   logic [NOUT-1:0]   mute_on_hold = 2'b01;
   logic [IW-1:0]     act_idx;
   logic [1:0]        qual;
   logic [2*NOUT-1:0] out_pol;
   logic              diag_disagree;
   logic              log_valid;
   logic [IW-1:0]     log_from;
   logic [IW-1:0]     log_to;
   logic [SW-1:0]     log_from_score;
   logic [SW-1:0]     log_to_score;
   logic [1:0]        log_reason;

   int total = 0;
   int bad   = 0;
   logic [RECW-1:0] expq[$];

   always #2 clk = ~clk;

   tsa_arbiter uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .src_valid(src_valid),
      .src_conf(src_conf), .src_stab(src_stab), .src_anom(src_anom),
      .quar_set(quar_set), .quar_clr(quar_clr), .margin(margin),
      .dwell_len(dwell_len), .thr_good(thr_good), .thr_poor(thr_poor),
      .dis_thr(dis_thr), .mute_on_hold(mute_on_hold), .act_idx(act_idx),
      .qual(qual), .out_pol(out_pol), .diag_disagree(diag_disagree),
      .log_valid(log_valid), .log_from(log_from), .log_to(log_to),
      .log_from_score(log_from_score), .log_to_score(log_to_score),
      .log_reason(log_reason)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_src(input int i, input logic [7:0] c, input logic [7:0] s, input logic [3:0] a);
      src_conf[i*8 +: 8] = c;
      src_stab[i*8 +: 8] = s;
      src_anom[i*4 +: 4] = a;
   endtask

   // expected score per R2, computed independently
   function automatic int hscore(input int c, input int s, input int a);
      return c + s + 4 * (15 - a);
   endfunction

   task automatic expect_log(input int f, input int t, input int fs, input int ts, input int r);
      expq.push_back({IW'(f), IW'(t), SW'(fs), SW'(ts), 2'(r)});
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   // monitor: every log record is compared with the scoreboard head (R6)
   always @(negedge clk) begin
      if (rst_n && log_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R6 unexpected log record", int'(log_to), -1);
         end else begin
            logic [RECW-1:0] e;
            e = expq.pop_front();
            chk({log_from, log_to, log_from_score, log_to_score, log_reason} == e,
                "R6 log record", int'({log_from, log_to, log_from_score, log_to_score, log_reason}), int'(e));
         end
      end
   end

   bit done = 1'b0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // sources: 460, 420, 240, 100 (R2)
      src_valid = 4'b1111;
      set_src(0, 200, 200, 0);
      set_src(1, 180, 180, 0);
      set_src(2, 100, 100, 5);
      set_src(3, 50, 50, 15);
      repeat (3) step();
      chk(act_idx == 0, "R1 reset index", act_idx, 0);
      chk(qual == 2, "R1 reset quality", qual, 2);
      chk(!log_valid && !diag_disagree, "R1 reset log/diag", log_valid, 0);
      chk(out_pol == 4'b1011, "R9 holdover policy in reset", out_pol, 4'b1011);
      rst_n = 1'b1;
      step();
      chk(act_idx == 0, "R1 index after reset", act_idx, 0);
      chk(qual == 0, "R8 holdover to nominal", qual, 0);
      chk(out_pol == 4'b0000, "R9 nominal policy", out_pol, 0);

      // R3: challenger src1 at 520 beats 460+20 after three ticks
      set_src(1, 230, 230, 0);
      pulse_tick();
      pulse_tick();
      chk(act_idx == 0, "R3 no switch before dwell", act_idx, 0);
      expect_log(0, 1, hscore(200, 200, 0), hscore(230, 230, 0), 1);
      pulse_tick();
      chk(act_idx == 1, "R3 switch at dwell", act_idx, 1);

      // R4: 530 does not exceed 520+20
      set_src(0, 235, 235, 0);
      repeat (5) pulse_tick();
      chk(act_idx == 1, "R4 margin not exceeded", act_idx, 1);

      // R3: count restarts when condition fails on a tick
      set_src(0, 255, 255, 0);
      pulse_tick();
      pulse_tick();
      set_src(0, 235, 235, 0);
      pulse_tick();
      set_src(0, 255, 255, 0);
      pulse_tick();
      pulse_tick();
      chk(act_idx == 1, "R3 dwell restarted", act_idx, 1);
      expect_log(1, 0, 520, 570, 1);
      pulse_tick();
      chk(act_idx == 0, "R3 switch after restart", act_idx, 0);

      // R5: active invalid, forced failover without tick
      expect_log(0, 1, 570, 520, 2);
      src_valid[0] = 1'b0;
      step();
      chk(act_idx == 1, "R5 forced failover", act_idx, 1);

      // R10: quarantine best source, forced to src2 (240)
      expect_log(1, 2, 520, 240, 2);
      quar_set[1] = 1'b1;
      step();
      quar_set[1] = 1'b0;
      chk(act_idx == 2, "R10 quarantined source dropped", act_idx, 2);
      chk(qual == 1, "R8 nominal to degraded", qual, 1);
      chk(out_pol == 4'b0101, "R9 degraded policy", out_pol, 4'b0101);
      repeat (4) pulse_tick();
      chk(act_idx == 2, "R10 quarantined source stays excluded", act_idx, 2);

      // R8 hysteresis on src2
      set_src(2, 145, 145, 0);
      step();
      chk(qual == 1, "R8 350 stays degraded", qual, 1);
      set_src(2, 175, 175, 0);
      step();
      chk(qual == 0, "R8 410 returns nominal", qual, 0);
      set_src(2, 145, 145, 0);
      step();
      chk(qual == 0, "R8 350 stays nominal", qual, 0);
      set_src(2, 115, 115, 0);
      step();
      chk(qual == 1, "R8 290 degrades", qual, 1);

      // R7: no eligible source
      src_valid = 4'b0000;
      step();
      chk(qual == 2, "R7 holdover", qual, 2);
      chk(act_idx == 2, "R7 index held", act_idx, 2);
      chk(out_pol == 4'b1011, "R9 holdover policy mute/hold", out_pol, 4'b1011);
      repeat (3) pulse_tick();
      chk(act_idx == 2, "R7 index held over ticks", act_idx, 2);

      // R10 clear, recovery onto src1
      quar_clr = 1'b1;
      step();
      quar_clr = 1'b0;
      expect_log(2, 1, 290, 520, 2);
      src_valid[1] = 1'b1;
      step();
      chk(act_idx == 1, "R10 cleared source usable", act_idx, 1);
      chk(qual == 0, "R8 holdover exit to nominal", qual, 0);

      // R11 disagreement
      src_valid[0] = 1'b1;
      step();
      chk(diag_disagree == 0, "R11 small gap", diag_disagree, 0);
      set_src(1, 150, 230, 0);
      step();
      chk(diag_disagree == 1, "R11 large gap flagged", diag_disagree, 1);
      src_valid[0] = 1'b0;
      step();
      chk(diag_disagree == 0, "R11 needs both valid", diag_disagree, 0);

      repeat (2) step();
      chk(expq.size() == 0, "R6 all records seen", expq.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule